// File: doc/BRIEF.md
# SPI Flash Read Traffic Snooper

This block listens, without driving anything, to the four wires of a single-bit SPI link between a host and a 25-series NOR flash: chip select (active low), serial clock, host-to-flash data and flash-to-host data. It samples all four lines with its own system clock through a synchronizer, rebuilds bytes from the rising edges of the serial clock, and treats each chip-select-low interval as one frame that begins with an opcode byte.

For the read commands it recognises, the block emits one record per byte returned by the flash. A record carries the address space it belongs to (main array, discoverable-parameter table or unique ID), its byte address and the byte itself. The record strobe marks that byte as observed, so a downstream store can build a memory image together with a presence mask in which never-read bytes stay at zero. The block also follows the flash's address-width state across frames: commands that enter or leave the wide addressing mode change how many address bytes later main-array reads carry. Opcodes outside the known set raise a one-cycle flag, and the rest of that frame is ignored.

Top module: `spi_flash_snoop`

## Requirements
- R1: After reset `rec_valid` and `bad_opcode` are 0 and `addr4_mode` is 0, meaning 3-byte main-array addressing.
- R2: Opcode 03h is a main-array read: the address bytes follow (most significant byte first), there is no dummy byte, and every later byte yields a record with `rec_region` = 0, the CIPO byte, and an address that starts at the sent address and rises by one per record.
- R3: Opcode 0Bh is a main-array read like 03h, except that one dummy byte after the address produces no record.
- R4: Opcode 5Ah reads the parameter table: records carry `rec_region` = 1, the address is always 3 bytes whatever `addr4_mode` is, and one dummy byte follows the address.
- R5: Opcode 4Bh reads the unique ID: no address is sent, four dummy bytes follow the opcode, and the records carry `rec_region` = 2 with addresses 0, 1, 2 and so on.
- R6: Opcode B7h sets `addr4_mode` to 1 and E9h clears it to 0; the state lasts across frames, and while it is 1, opcodes 03h and 0Bh take 4 address bytes. No other event changes `addr4_mode`.
- R7: Opcodes 9Fh, 05h, 06h and 04h produce no records and do not raise `bad_opcode`. Any bytes that follow in the same frame, including ones equal to known opcodes, have no effect.
- R8: Any other opcode pulses `bad_opcode` for one cycle. The rest of that frame produces no records and does not change `addr4_mode`.
- R9: Bytes are assembled most significant bit first from samples taken at the rising edges of SCK. The opcode and address come from COPI, and record data comes from CIPO.
- R10: A rising edge on chip select ends the frame and discards any partial byte. The next frame starts fresh with an opcode byte, and its records are unaffected by the earlier frame.
- R11: `rec_valid` and `bad_opcode` are single-cycle pulses that occur 4 clock cycles after the system-clock cycle in which SCK rises for the eighth bit of the byte (2 cycles of synchronization, 1 to assemble the byte, 1 to decode it). Two records are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Observed flash chip select, active low |
| sck | input | 1 | Observed serial clock |
| copi | input | 1 | Observed host-to-flash data line |
| cipo | input | 1 | Observed flash-to-host data line |
| rec_valid | output | 1 | One-cycle strobe: a record is present and its byte is observed |
| rec_region | output | 2 | Address space of the record: 0 main array, 1 parameter table, 2 unique ID |
| rec_addr | output | ADDR_W | Byte address of the record within its address space |
| rec_byte | output | 8 | Byte returned by the flash |
| bad_opcode | output | 1 | One-cycle strobe: the frame's opcode is not recognised |
| addr4_mode | output | 1 | Current main-array address width: 1 for 4 bytes, 0 for 3 bytes |

## Verification
Each result is due exactly four system-clock cycles after the SCK rising edge that completes a byte. The bench holds each SCK level for six clock cycles, so a record or flag always settles while SCK is still high. A monitor samples both strobes on the falling clock edge and logs every record in order. A driver measures the number of falling edges from the last rising SCK edge of a data byte to the strobe and compares it with four. The frame-level checks run only after chip select has risen and several more cycles have passed, so every pulse still pending from the frame has been logged.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    RG_DATA  = 2'd0,
    RG_PARAM = 2'd1,
    RG_UID   = 2'd2,
    RG_NONE  = 2'd3
  } region_t;

  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_t;

  typedef struct packed {
    region_t    region;
    logic [2:0] addr_len;
    logic [2:0] dummy_len;
    logic       known;
    logic       set4;
    logic       clr4;
  } opinfo_t;

  // Classify an opcode byte given the current address-width state.
  function automatic opinfo_t decode_op(input logic [7:0] op,
                                        input logic       wide,
                                        input logic [2:0] uid_dummy);
    opinfo_t r;
    r.region    = RG_NONE;
    r.addr_len  = 3'd0;
    r.dummy_len = 3'd0;
    r.known     = 1'b1;
    r.set4      = 1'b0;
    r.clr4      = 1'b0;
    case (op)
      8'h03: begin
        r.region   = RG_DATA;
        r.addr_len = wide ? 3'd4 : 3'd3;
      end
      8'h0B: begin
        r.region    = RG_DATA;
        r.addr_len  = wide ? 3'd4 : 3'd3;
        r.dummy_len = 3'd1;
      end
      8'h5A: begin
        r.region    = RG_PARAM;
        r.addr_len  = 3'd3;
        r.dummy_len = 3'd1;
      end
      8'h4B: begin
        r.region    = RG_UID;
        r.dummy_len = uid_dummy;
      end
      8'hB7: r.set4 = 1'b1;
      8'hE9: r.clr4 = 1'b1;
      8'h9F, 8'h05, 8'h06, 8'h04: r.known = 1'b1;
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

  // Phase that follows the last address byte or the opcode.
  function automatic phase_t after_addr(input logic [2:0] dummy_len);
    return (dummy_len != 3'd0) ? PH_DUMMY : PH_DATA;
  endfunction

endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/snoop_shift.sv
module snoop_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          mo_s,
  input  logic          mi_s,
  output logic          byte_done,
  output logic [BW-1:0] mo_byte,
  output logic [BW-1:0] mi_byte,
  output logic          frame_end,
  output logic          in_idle
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic          sck_d, cs_d;
  logic [CW-1:0] bitcnt;
  logic          sck_rise;

  assign sck_rise  = sck_s & ~sck_d;
  assign frame_end = cs_s & ~cs_d;
  assign in_idle   = cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      cs_d      <= 1'b1;
      bitcnt    <= '0;
      byte_done <= 1'b0;
      mo_byte   <= '0;
      mi_byte   <= '0;
    end else begin
      sck_d     <= sck_s;
      cs_d      <= cs_s;
      byte_done <= 1'b0;
      if (cs_s) begin
        bitcnt <= '0;
      end else if (sck_rise) begin
        mo_byte <= {mo_byte[BW-2:0], mo_s};
        mi_byte <= {mi_byte[BW-2:0], mi_s};
        if (bitcnt == LAST) begin
          bitcnt    <= '0;
          byte_done <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/snoop_decode.sv
module snoop_decode
  import snoop_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BW        = 8,
  parameter int UID_DUMMY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [BW-1:0] mo_byte,
  input  logic [BW-1:0] mi_byte,
  input  logic          in_idle,
  output logic          rec_valid,
  output logic [1:0]    rec_region,
  output logic [AW-1:0] rec_addr,
  output logic [BW-1:0] rec_byte,
  output logic          bad_opcode,
  output logic          addr4_mode,
  output logic          opc_strobe
);
  localparam logic [2:0] UIDD = 3'(UID_DUMMY);

  phase_t        phase;
  region_t       region;
  logic [2:0]    cnt;
  logic [2:0]    dummy_len;
  logic [AW-1:0] addr;
  opinfo_t       info;

  assign opc_strobe = byte_done && (phase == PH_OPC);
  assign info       = decode_op(mo_byte, addr4_mode, UIDD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_OPC;
      region     <= RG_NONE;
      cnt        <= '0;
      dummy_len  <= '0;
      addr       <= '0;
      addr4_mode <= 1'b0;
      rec_valid  <= 1'b0;
      rec_region <= 2'd0;
      rec_addr   <= '0;
      rec_byte   <= '0;
      bad_opcode <= 1'b0;
    end else begin
      rec_valid  <= 1'b0;
      bad_opcode <= 1'b0;
      if (byte_done) begin
        case (phase)
          PH_OPC: begin
            region    <= info.region;
            addr      <= '0;
            dummy_len <= info.dummy_len;
            if (info.set4) addr4_mode <= 1'b1;
            if (info.clr4) addr4_mode <= 1'b0;
            if (!info.known) begin
              bad_opcode <= 1'b1;
              phase      <= PH_SKIP;
            end else if (info.region == RG_NONE) begin
              phase <= PH_SKIP;
            end else if (info.addr_len != 3'd0) begin
              cnt   <= info.addr_len;
              phase <= PH_ADDR;
            end else begin
              cnt   <= info.dummy_len;
              phase <= after_addr(info.dummy_len);
            end
          end
          PH_ADDR: begin
            addr <= {addr[AW-BW-1:0], mo_byte};
            if (cnt == 3'd1) begin
              cnt   <= dummy_len;
              phase <= after_addr(dummy_len);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt == 3'd1) phase <= PH_DATA;
            else             cnt   <= cnt - 1'b1;
          end
          PH_DATA: begin
            rec_valid  <= 1'b1;
            rec_region <= region;
            rec_addr   <= addr;
            rec_byte   <= mi_byte;
            addr       <= addr + 1'b1;
          end
          default: ;
        endcase
      end
      if (in_idle) phase <= PH_OPC;
    end
  end
endmodule

// File: rtl/spi_flash_snoop.sv
module spi_flash_snoop #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 32,
  parameter int UID_DUMMY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              copi,
  input  logic              cipo,
  output logic              rec_valid,
  output logic [1:0]        rec_region,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [7:0]        rec_byte,
  output logic              bad_opcode,
  output logic              addr4_mode
);
  localparam int BW = 8;

  logic [3:0]    raw, synced;
  logic          byte_done, frame_end, in_idle, opc_strobe;
  logic [BW-1:0] mo_byte, mi_byte;

  assign raw = {cs_n, sck, copi, cipo};

  snoop_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  snoop_shift #(.BW(BW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_s(synced[3]), .sck_s(synced[2]), .mo_s(synced[1]), .mi_s(synced[0]),
    .byte_done(byte_done), .mo_byte(mo_byte), .mi_byte(mi_byte),
    .frame_end(frame_end), .in_idle(in_idle)
  );

  snoop_decode #(.AW(ADDR_W), .BW(BW), .UID_DUMMY(UID_DUMMY)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .byte_done(byte_done), .mo_byte(mo_byte), .mi_byte(mi_byte),
    .in_idle(in_idle),
    .rec_valid(rec_valid), .rec_region(rec_region), .rec_addr(rec_addr),
    .rec_byte(rec_byte), .bad_opcode(bad_opcode), .addr4_mode(addr4_mode),
    .opc_strobe(opc_strobe)
  );
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_valid,
  input logic [1:0]    rec_region,
  input logic [AW-1:0] rec_addr,
  input logic          bad_opcode,
  input logic          addr4_mode,
  input logic          byte_done,
  input logic          opc_strobe,
  input logic          frame_end
);
  logic [AW-1:0] last_addr;
  logic          have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_prev <= 1'b0;
    end else if (frame_end) begin
      have_prev <= 1'b0;
    end else if (rec_valid) begin
      last_addr <= rec_addr;
      have_prev <= 1'b1;
    end
  end

  AST_REC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);                                   // R11
  AST_REC_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(byte_done));                             // R11
  AST_BAD_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && bad_opcode));                                 // R8
  AST_BAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |=> !bad_opcode);                                 // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && have_prev) |-> rec_addr == last_addr + 1'b1);  // R2
  AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_region != 2'd3);                           // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !opc_strobe |=> $stable(addr4_mode));                        // R6
endmodule

bind spi_flash_snoop snoop_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_region(rec_region),
  .rec_addr(rec_addr), .bad_opcode(bad_opcode), .addr4_mode(addr4_mode),
  .byte_done(byte_done), .opc_strobe(opc_strobe), .frame_end(frame_end)
);

// File: tb/sim_spi_flash_snoop.sv
`timescale 1ns/1ps
module sim_spi_flash_snoop;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, copi = 1'b0, cipo = 1'b0;
  logic        rec_valid, bad_opcode, addr4_mode;
  logic [1:0]  rec_region;
  logic [31:0] rec_addr;
  logic [7:0]  rec_byte;

  int nvec = 0, nbad = 0;
  int cap_n = 0, bad_seen = 0, lat_first = -1;
  logic [1:0]  cap_reg  [16];
  logic [31:0] cap_addr [16];
  logic [7:0]  cap_byte [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_snoop u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .copi(copi), .cipo(cipo),
    .rec_valid(rec_valid), .rec_region(rec_region), .rec_addr(rec_addr),
    .rec_byte(rec_byte), .bad_opcode(bad_opcode), .addr4_mode(addr4_mode)
  );

  always @(negedge clk) begin
    if (rec_valid && cap_n < 16) begin
      cap_reg[cap_n]  = rec_region;
      cap_addr[cap_n] = rec_addr;
      cap_byte[cap_n] = rec_byte;
      cap_n = cap_n + 1;
    end
    if (bad_opcode) bad_seen = bad_seen + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    cap_n = 0; bad_seen = 0; lat_first = -1;
  endtask

  // Send the top nbits of a byte on COPI and CIPO, MSB first.
  task automatic spi_bits(input logic [7:0] mo, input logic [7:0] mi, input int nbits);
    for (int i = 7; i >= 8 - nbits; i--) begin
      copi = mo[i]; cipo = mi[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      for (int k = 1; k <= HALF; k++) begin
        @(negedge clk);
        if (rec_valid && i == 0 && lat_first < 0) lat_first = k;
      end
      sck = 1'b0;
    end
  endtask

  // One frame of n bytes; the bytes sit in the low 8*n bits, first byte highest.
  task automatic xfer(input int n, input logic [95:0] mo, input logic [95:0] mi);
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++)
      spi_bits(mo[8*(n-1-k) +: 8], mi[8*(n-1-k) +: 8], 8);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic exp_rec(input string tag, input int idx, input logic [1:0] rg,
                         input logic [31:0] a, input logic [7:0] b);
    chk({tag, " region"}, 64'(cap_reg[idx]), 64'(rg));
    chk({tag, " addr"},   64'(cap_addr[idx]), 64'(a));
    chk({tag, " byte"},   64'(cap_byte[idx]), 64'(b));
  endtask

  task automatic t_reset();
    chk("R1 rec_valid", 64'(rec_valid), 64'd0);
    chk("R1 bad_opcode", 64'(bad_opcode), 64'd0);
    chk("R1 addr4_mode", 64'(addr4_mode), 64'd0);
  endtask

  task automatic t_read03();
    clear_log();
    xfer(7, {8'h03, 8'h12, 8'h34, 8'h56, 8'hFF, 8'hFF, 8'hFF},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'hD0, 8'h81, 8'h2C});
    chk("R2 record count", 64'(cap_n), 64'd3);
    exp_rec("R2 r0", 0, 2'd0, 32'h123456, 8'hD0);
    exp_rec("R2 r1", 1, 2'd0, 32'h123457, 8'h81);
    exp_rec("R9 r2", 2, 2'd0, 32'h123458, 8'h2C);
    chk("R11 latency", 64'(lat_first), 64'd4);
  endtask

  task automatic t_fast0B();
    clear_log();
    xfer(7, {8'h0B, 8'h00, 8'h01, 8'hFE, 8'h00, 8'h00, 8'h00},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'h99, 8'h3C, 8'hC3});
    chk("R3 record count", 64'(cap_n), 64'd2);
    exp_rec("R3 r0", 0, 2'd0, 32'h0001FE, 8'h3C);
    exp_rec("R3 r1", 1, 2'd0, 32'h0001FF, 8'hC3);
  endtask

  task automatic t_param();
    clear_log();
    xfer(7, {8'h5A, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'hEE, 8'h53, 8'h46});
    chk("R4 record count", 64'(cap_n), 64'd2);
    exp_rec("R4 r0", 0, 2'd1, 32'h10, 8'h53);
    exp_rec("R4 r1", 1, 2'd1, 32'h11, 8'h46);
  endtask

  task automatic t_uid();
    clear_log();
    xfer(8, {8'h4B, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h00, 8'h00},
            {8'h00, 8'h77, 8'h77, 8'h77, 8'h77, 8'hA1, 8'hB2, 8'hC3});
    chk("R5 record count", 64'(cap_n), 64'd3);
    exp_rec("R5 r0", 0, 2'd2, 32'd0, 8'hA1);
    exp_rec("R5 r1", 1, 2'd2, 32'd1, 8'hB2);
    exp_rec("R5 r2", 2, 2'd2, 32'd2, 8'hC3);
  endtask

  task automatic t_mode4();
    clear_log();
    xfer(1, 96'h B7, 96'h0);
    chk("R6 mode set", 64'(addr4_mode), 64'd1);
    xfer(6, {8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5E});
    xfer(6, {8'h5A, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h6F});
    chk("R6 mode persists", 64'(addr4_mode), 64'd1);
    xfer(1, 96'h E9, 96'h0);
    chk("R6 mode cleared", 64'(addr4_mode), 64'd0);
    xfer(5, {8'h03, 8'h00, 8'h00, 8'h05, 8'h00},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'h7A});
    chk("R6 record count", 64'(cap_n), 64'd3);
    exp_rec("R6 wide read", 0, 2'd0, 32'h01020304, 8'h5E);
    exp_rec("R4 param in wide mode", 1, 2'd1, 32'h20, 8'h6F);
    exp_rec("R6 narrow again", 2, 2'd0, 32'h05, 8'h7A);
  endtask

  task automatic t_nonrec();
    clear_log();
    xfer(4, {8'h9F, 8'h03, 8'h00, 8'h00}, {8'h00, 8'hEF, 8'h40, 8'h16});
    xfer(3, {8'h05, 8'h00, 8'h00}, {8'h00, 8'h03, 8'h02});
    xfer(2, {8'h06, 8'hB7}, 16'h0);
    xfer(1, 96'h04, 96'h0);
    chk("R7 no records", 64'(cap_n), 64'd0);
    chk("R7 no flag", 64'(bad_seen), 64'd0);
    chk("R7 trailing B7 ignored", 64'(addr4_mode), 64'd0);
  endtask

  task automatic t_unknown();
    clear_log();
    xfer(6, {8'h77, 8'h03, 8'h00, 8'h00, 8'h00, 8'hB7},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'hAA, 8'hAA});
    chk("R8 flag pulses", 64'(bad_seen), 64'd1);
    chk("R8 no records", 64'(cap_n), 64'd0);
    chk("R8 mode untouched", 64'(addr4_mode), 64'd0);
  endtask

  task automatic t_partial();
    clear_log();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_bits(8'h03, 8'h00, 8);
    spi_bits(8'h00, 8'h00, 8);
    spi_bits(8'h00, 8'h00, 8);
    spi_bits(8'h10, 8'h00, 8);
    spi_bits(8'h00, 8'h11, 8);
    spi_bits(8'hFF, 8'hFF, 3);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
    xfer(5, {8'h03, 8'h00, 8'h00, 8'h20, 8'h00},
            {8'h00, 8'h00, 8'h00, 8'h00, 8'h22});
    chk("R10 record count", 64'(cap_n), 64'd2);
    exp_rec("R10 r0", 0, 2'd0, 32'h10, 8'h11);
    exp_rec("R10 fresh frame", 1, 2'd0, 32'h20, 8'h22);
    chk("R10 no flag", 64'(bad_seen), 64'd0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read03();
    t_fast0B();
    t_param();
    t_uid();
    t_mode4();
    t_nonrec();
    t_unknown();
    t_partial();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule